// File: doc/BRIEF.md
# Converter Timing Sequencer

This block paces a successive-approximation analog-to-digital converter. It derives a symmetric converter clock from the peripheral clock. It then walks each conversion through two phases: a final-sample window, followed by the resolution-dependent bit-decision periods. When the last converter clock period of a conversion ends, it emits a one-cycle completion pulse. The comparator, the result storage and the channel sequencing sit outside the block. Here the bit decisions are simply counted converter clock periods.

Software loads one control byte over a write strobe. The byte holds the resolution, the sample-window code and the prescaler divisor. A separate start strobe launches a conversion. Writing the control byte while a conversion runs abandons it, and the block stays idle until the next start. A debug-active input, together with a two-bit freeze selection, lets a halted system either leave the converter running, let the current conversion finish and hold the next one, or stop it on the spot. A frozen conversion later resumes exactly where it stopped.

The control byte has three fields. Bit 7 selects the resolution: 0 is 8-bit and 1 is 10-bit. Bits 6:5 hold the sample-window code. Bits 4:0 hold the divisor PRS.

Top module: `adc_seq_timer`

## Requirements
- R1: After reset `busy`, `done`, `sampling` and `conv_clk` are low. The control fields reset to 8-bit mode, sample code 00 and divisor 1, so a start with no prior control write lasts 72 peripheral clock cycles.
- R2: While busy, `conv_clk` starts low at the start edge and toggles every PRS+1 peripheral cycles. Its first high half therefore lasts PRS+1 cycles, and one converter period is 2·(PRS+1) cycles. It is low whenever the block is idle.
- R3: A divisor field of 0 gives the same timing as a divisor of 1.
- R4: `sampling` is high for the first 2, 4, 8 or 16 converter periods of a conversion, for sample codes 00, 01, 10 and 11 (bits 6:5).
- R5: With bit 7 = 0 (8-bit), a conversion lasts 16 converter periods plus the sample window, which is 18, 20, 24 or 32 periods.
- R6: With bit 7 = 1 (10-bit), a conversion lasts 18 converter periods plus the sample window, which is 20, 22, 26 or 34 periods.
- R7: `done` is high for exactly one peripheral cycle, in the cycle where `busy` first reads low after a completed conversion. `busy` stays high from the cycle after the start strobe through the last period.
- R8: A control write without a start strobe during a conversion clears `busy` on the next cycle and produces no `done`. The block then stays idle with `conv_clk` low until a start strobe.
- R9: A start strobe during a conversion restarts it from the first sample period. A start strobe together with a control write starts a conversion that uses the newly written fields.
- R10: Freeze code 11 holds every counter, including the prescaler, in each cycle in which debug is active during a conversion. Each such cycle lengthens the conversion by exactly one cycle.
- R11: With freeze code 10, a conversion that has already advanced runs to completion regardless of debug. A conversion started while debug is active holds at its first step until debug drops.
- R12: Freeze codes 00 and 01 ignore the debug input entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte: [7] resolution, [6:5] sample code, [4:0] divisor |
| start_wr | input | 1 | Conversion start strobe |
| dbg_active | input | 1 | Debug halt indication |
| frz_sel | input | 2 | Freeze policy: 00 run, 01 run, 10 finish then hold, 11 hold at once |
| conv_clk | output | 1 | Symmetric converter clock |
| sampling | output | 1 | High during the final-sample window |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench measures the length of each conversion in peripheral cycles, along with its sample window, its period count and its first clock half, against values computed from the divisor, sample code and resolution. A prescaler that ignored the divide-by-two stage or mishandled divisor 0 would shift every one of those counts. The bench aborts a conversion midway and then idles, which exposes a block that still pulses `done` or keeps clocking after an abort. It restarts a conversion in flight and combines a start with a control write, which catches a design that uses stale fields or keeps its old period count. For the freeze codes, it holds debug for a known number of cycles, both at the start and midway. A design that ignored the policy, treated code 10 as code 11, or lost prescaler state while frozen would then finish early or late by a visible number of cycles.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int unsigned PRS_W  = 5;
    localparam int unsigned SMP_W  = 2;
    localparam int unsigned PER_W  = 6;
    localparam int unsigned LEN_LO = 16;
    localparam int unsigned LEN_HI = 18;
    localparam logic [PRS_W-1:0] PRS_RESET = PRS_W'(1);

    typedef struct packed {
        logic             hires;
        logic [SMP_W-1:0] smp;
        logic [PRS_W-1:0] prs;
    } ctl_t;

    localparam int unsigned CTL_W = $bits(ctl_t);

    typedef enum logic [1:0] {
        FRZ_RUN   = 2'b00,
        FRZ_RSV   = 2'b01,
        FRZ_AFTER = 2'b10,
        FRZ_NOW   = 2'b11
    } frz_e;

    function automatic logic [PER_W-1:0] sample_periods(input logic [SMP_W-1:0] s);
        return PER_W'(2) << s;
    endfunction

    function automatic logic [PER_W-1:0] total_periods(input ctl_t c);
        return sample_periods(c.smp) + (c.hires ? PER_W'(LEN_HI) : PER_W'(LEN_LO));
    endfunction

    function automatic logic [PRS_W-1:0] eff_div(input logic [PRS_W-1:0] p);
        return (p == '0) ? PRS_W'(1) : p;
    endfunction

endpackage

// File: rtl/adc_seq_ctlreg.sv
module adc_seq_ctlreg
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    output ctl_t             ctl
);

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr) begin
            ctl_d = ctl_t'(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{hires: 1'b0, smp: '0, prs: PRS_RESET};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ctl = ctl_q;

endmodule

// File: rtl/adc_seq_prescaler.sv
module adc_seq_prescaler
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    input  logic [PRS_W-1:0] prs,
    output logic             conv_clk,
    output logic             period_end
);

    typedef struct packed {
        logic [PRS_W-1:0] cnt;
        logic             half;
    } pre_t;

    pre_t             pre_d, pre_q;
    logic [PRS_W-1:0] div;
    logic             tick;

    always_comb begin
        div   = eff_div(prs);
        tick  = advance && (pre_q.cnt >= div);
        pre_d = pre_q;
        if (clear) begin
            pre_d = '0;
        end else if (tick) begin
            pre_d.cnt  = '0;
            pre_d.half = ~pre_q.half;
        end else if (advance) begin
            pre_d.cnt = pre_q.cnt + PRS_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

    assign conv_clk   = pre_q.half;
    assign period_end = tick && pre_q.half;

    AST_PRESCALE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q.cnt <= div); // R2

    AST_PERIOD_ENDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |=> !conv_clk); // R2

endmodule

// File: rtl/adc_seq_phase.sv
module adc_seq_phase
    import adc_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    input  logic period_end,
    input  ctl_t ctl,
    output logic busy,
    output logic sampling,
    output logic done
);

    typedef struct packed {
        logic             busy;
        logic [PER_W-1:0] per;
        logic             done;
    } ph_t;

    ph_t              ph_d, ph_q;
    logic [PER_W-1:0] last_per;
    logic [PER_W-1:0] samp_per;

    always_comb begin
        last_per  = total_periods(ctl) - PER_W'(1);
        samp_per  = sample_periods(ctl.smp);
        ph_d      = ph_q;
        ph_d.done = 1'b0;
        if (start) begin
            ph_d.busy = 1'b1;
            ph_d.per  = '0;
        end else if (abort) begin
            ph_d.busy = 1'b0;
            ph_d.per  = '0;
        end else if (ph_q.busy && period_end) begin
            if (ph_q.per == last_per) begin
                ph_d.busy = 1'b0;
                ph_d.per  = '0;
                ph_d.done = 1'b1;
            end else begin
                ph_d.per = ph_q.per + PER_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_d;
        end
    end

    assign busy     = ph_q.busy;
    assign done     = ph_q.done;
    assign sampling = ph_q.busy && (ph_q.per < samp_per);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q.done |=> !ph_q.done); // R7

    AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q.done |-> (!ph_q.busy && $past(ph_q.busy))); // R7

    AST_PER_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q.busy |-> (ph_q.per <= last_per)); // R5

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             start_wr,
    input  logic             dbg_active,
    input  logic [1:0]       frz_sel,
    output logic             conv_clk,
    output logic             sampling,
    output logic             busy,
    output logic             done
);

    typedef struct packed {
        logic moving;
    } top_t;

    top_t top_d, top_q;
    ctl_t ctl;
    frz_e pol;
    logic stall;
    logic advance;
    logic abort;
    logic clear;
    logic period_end;

    adc_seq_ctlreg u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (ctl_wr),
        .wdata (ctl_wdata),
        .ctl   (ctl)
    );

    always_comb begin
        pol     = frz_e'(frz_sel);
        stall   = busy && dbg_active &&
                  ((pol == FRZ_NOW) || ((pol == FRZ_AFTER) && !top_q.moving));
        advance = busy && !stall;
        abort   = ctl_wr && !start_wr;
        clear   = ctl_wr || start_wr;
        top_d   = top_q;
        if (start_wr) begin
            top_d.moving = 1'b0;
        end else if (advance) begin
            top_d.moving = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    adc_seq_prescaler u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .advance    (advance),
        .prs        (ctl.prs),
        .conv_clk   (conv_clk),
        .period_end (period_end)
    );

    adc_seq_phase u_ph (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_wr),
        .abort      (abort),
        .period_end (period_end),
        .ctl        (ctl),
        .busy       (busy),
        .sampling   (sampling),
        .done       (done)
    );

    AST_FREEZE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !start_wr && !ctl_wr) |=> ($stable(conv_clk) && busy && !done)); // R10

    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !start_wr) |=> (!busy && !done)); // R8

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !conv_clk); // R2

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> (busy && !done)); // R7

endmodule

// File: tb/sim_adc_seq_timer.sv
`timescale 1ns/1ps
module sim_adc_seq_timer;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ctl_wr;
    logic [7:0] ctl_wdata;
    logic       start_wr;
    logic       dbg_active;
    logic [1:0] frz_sel;
    logic       conv_clk, sampling, busy, done;

    always #2.5 clk = ~clk;

    adc_seq_timer u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr),
        .ctl_wdata  (ctl_wdata),
        .start_wr   (start_wr),
        .dbg_active (dbg_active),
        .frz_sel    (frz_sel),
        .conv_clk   (conv_clk),
        .sampling   (sampling),
        .busy       (busy),
        .done       (done)
    );

    typedef struct {
        int    len;
        int    samp;
        int    per;
        int    hi;
        bit    abrt;
        string tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic int dv(input int p);
        return (p == 0) ? 1 : p;
    endfunction
    function automatic int speriods(input int s);
        return 2 << s;
    endfunction
    function automatic int tperiods(input int m, input int s);
        return speriods(s) + (m != 0 ? 18 : 16);
    endfunction
    function automatic int cyc_len(input int m, input int s, input int p);
        return tperiods(m, s) * 2 * (dv(p) + 1);
    endfunction
    function automatic int cyc_samp(input int s, input int p);
        return speriods(s) * 2 * (dv(p) + 1);
    endfunction

    task automatic push(input int len, input int samp, input int per, input int hi,
                        input bit ab, input string tag);
        exp_t e;
        e.len = len; e.samp = samp; e.per = per; e.hi = hi; e.abrt = ab; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic write_cfg(input int m, input int s, input int p);
        @(negedge clk);
        ctl_wr    = 1'b1;
        ctl_wdata = {m[0], s[1:0], p[4:0]};
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start_wr = 1'b1;
        @(negedge clk);
        start_wr = 1'b0;
    endtask

    task automatic wait_idle();
        while (q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic conv(input int m, input int s, input int p, input string tag);
        write_cfg(m, s, p);
        push(cyc_len(m, s, p), cyc_samp(s, p), tperiods(m, s), dv(p) + 1, 1'b0, tag);
        pulse_start();
        wait_idle();
    endtask

    // Monitor: measures each busy interval and pops the matching expectation
    int cnt = 0, scnt = 0, rises = 0, hrun = 0;
    bit hdone = 0, cprev = 0, done_prev = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (done_prev) chk(done == 1'b0, "R7 done width", done, 0);
            done_prev = done;
            if (busy) begin
                cnt++;
                if (sampling) scnt++;
                if (conv_clk && !cprev) rises++;
                if (conv_clk && !hdone) hrun++;
                if (!conv_clk && hrun > 0) hdone = 1;
                cprev = conv_clk;
            end else if (cnt > 0) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R7 unexpected conversion", cnt, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(cnt == e.len, {e.tag, " length"}, cnt, e.len);
                    chk(done == !e.abrt, {e.tag, " done at end"}, done, !e.abrt);
                    if (e.samp >= 0) chk(scnt == e.samp, {e.tag, " sample window R4"}, scnt, e.samp);
                    if (e.per >= 0)  chk(rises == e.per, {e.tag, " periods"}, rises, e.per);
                    if (e.hi >= 0)   chk(hrun == e.hi, {e.tag, " clock high half R2"}, hrun, e.hi);
                end
                cnt = 0; scnt = 0; rises = 0; hrun = 0; hdone = 0; cprev = 0;
            end else if (done) begin
                chk(1'b0, "R8 done without conversion", done, 0);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ctl_wr = 1'b0; ctl_wdata = '0; start_wr = 1'b0;
        dbg_active = 1'b0; frz_sel = 2'b00;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(done == 1'b0, "R1 done after reset", done, 0);
        chk(conv_clk == 1'b0, "R1 clock after reset", conv_clk, 0);
        chk(sampling == 1'b0, "R1 sampling after reset", sampling, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset fields give 8-bit, code 00, divisor 1 -> 72 cycles
        push(72, 8, 18, 2, 1'b0, "R1 default fields");
        pulse_start();
        wait_idle();

        conv(0, 1, 3,  "R5 8-bit code01 div3");
        conv(0, 2, 0,  "R3 divisor zero");
        conv(0, 3, 2,  "R5 8-bit code11 div2");
        conv(1, 0, 1,  "R6 10-bit code00 div1");
        conv(1, 3, 5,  "R6 10-bit code11 div5");
        conv(1, 1, 31, "R2 10-bit code01 div31");

        // R8: abort midway, stay idle, then start with the new fields
        write_cfg(0, 0, 1);
        push(30, -1, -1, -1, 1'b1, "R8 abort");
        pulse_start();
        repeat (29) @(negedge clk);
        ctl_wr = 1'b1; ctl_wdata = {1'b1, 2'd0, 5'd2};
        @(negedge clk);
        ctl_wr = 1'b0;
        repeat (40) @(negedge clk);
        chk(busy == 1'b0, "R8 idle after abort", busy, 0);
        chk(conv_clk == 1'b0, "R8 clock idle after abort", conv_clk, 0);
        chk(q.size() == 0, "R8 abort observed", q.size(), 0);
        push(cyc_len(1, 0, 2), cyc_samp(0, 2), tperiods(1, 0), 3, 1'b0, "R8 start after abort");
        pulse_start();
        wait_idle();

        // R9: restart in flight
        write_cfg(0, 1, 1);
        push(25 + cyc_len(0, 1, 1), -1, -1, -1, 1'b0, "R9 restart");
        pulse_start();
        repeat (24) @(negedge clk);
        start_wr = 1'b1;
        @(negedge clk);
        start_wr = 1'b0;
        wait_idle();

        // R9: start together with control write uses new fields
        push(cyc_len(1, 3, 1), cyc_samp(3, 1), tperiods(1, 3), 2, 1'b0, "R9 start with write");
        @(negedge clk);
        ctl_wr = 1'b1; start_wr = 1'b1; ctl_wdata = {1'b1, 2'd3, 5'd1};
        @(negedge clk);
        ctl_wr = 1'b0; start_wr = 1'b0;
        wait_idle();

        // R10: hold at once, at start and midway
        write_cfg(0, 0, 1);
        frz_sel = 2'b11; dbg_active = 1'b1;
        push(72 + 25, 8 + 25, 18, -1, 1'b0, "R10 freeze at start");
        pulse_start();
        repeat (25) @(negedge clk);
        dbg_active = 1'b0;
        wait_idle();
        push(72 + 17, 8, 18, -1, 1'b0, "R10 freeze midway");
        pulse_start();
        repeat (40) @(negedge clk);
        dbg_active = 1'b1;
        repeat (17) @(negedge clk);
        dbg_active = 1'b0;
        wait_idle();

        // R11: finish then hold
        frz_sel = 2'b10;
        push(72, 8, 18, 2, 1'b0, "R11 running conversion completes");
        pulse_start();
        repeat (10) @(negedge clk);
        dbg_active = 1'b1;
        wait_idle();
        push(72 + 20, 8 + 20, 18, -1, 1'b0, "R11 new conversion held");
        pulse_start();
        repeat (20) @(negedge clk);
        dbg_active = 1'b0;
        wait_idle();

        // R12: run policies ignore debug
        frz_sel = 2'b00; dbg_active = 1'b1;
        push(72, 8, 18, 2, 1'b0, "R12 code00 ignores debug");
        pulse_start();
        wait_idle();
        frz_sel = 2'b01;
        push(72, 8, 18, 2, 1'b0, "R12 code01 ignores debug");
        pulse_start();
        wait_idle();
        dbg_active = 1'b0;

        chk(q.size() == 0, "R7 all conversions observed", q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule